// File: doc/BRIEF.md
# Power-Gating Domain Sequencer

This block switches a set of independently power-gated domains off and back on. Each domain has its own one-cycle sleep and wake request inputs. It also has a power-good acknowledge coming back from its switch network. For each domain the block drives:
- a power switch enable
- an isolation clamp enable
- a state-save strobe and a state-restore strobe for the retention shadow registers
- a clock enable
- a three-bit status code

A small isolation bank forces each domain's outward data bits to fixed levels while the domain is unpowered.

Going down, the steps run in a fixed safe order: clock stop, clamp, save, switch open, then a wait for the acknowledge to drop. Coming up, the order is switch close, a wait for the acknowledge, restore, clock start, and finally clamp release. A request never cuts a sequence short. A wake that arrives while the domain is shutting down is remembered and served once the domain is fully off. If an acknowledge wait runs longer than the programmed cycle limit, the domain parks in a safe error state with a sticky fault flag.

Top module: `pgc_ctrl`

## Requirements
- R1: After reset every domain has status 0, clock enable 1, switch enable 1, isolation 0, save 0, restore 0 and fault 0.
- R2: A sleep pulse sampled while a domain is ON drives its clock enable low on the next cycle. Isolation rises one cycle later. The save strobe is high for exactly the cycle after that. The switch enable falls in the following cycle, with isolation held.
- R3: Status codes are ON=0, GOING_OFF=1, OFF=2, GOING_ON=3, ERROR=4. A domain reports OFF only after it has sampled its acknowledge low while its switch enable is low.
- R4: A wake pulse sampled while OFF raises the switch enable on the next cycle. The restore strobe is high for one cycle, and only after the acknowledge has been sampled high. The clock enable rises in the cycle after restore. Isolation falls one cycle after that, and status returns to ON.
- R5: A wake pulse that arrives while a domain is GOING_OFF is held. The shutdown completes to OFF, and the wake-up then starts without a further request.
- R6: A sleep pulse is ignored unless the domain is ON, and a wake pulse is ignored while the domain is ON or GOING_ON.
- R7: The timeout input gives the limit L. If the acknowledge has not changed within L cycles of a wait starting, the domain enters ERROR. In ERROR, isolation is 1, the switch enable and clock enable are 0, fault is 1 until reset, and all requests are ignored.
- R8: While a domain's isolation is 0 its data outputs follow its data inputs. While isolation is 1 each output bit takes its bit of CLAMP_PAT. The default value is 16'h3C96, so the clamp values are 6, 9, C and 3 for domains 0 to 3.
- R9: Domains sequence independently. Activity on one never changes another's outputs.
- R10: Save and restore strobes never overlap, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_limit | input | TMO_W | Acknowledge wait limit in cycles (at least 1) |
| sleep_req | input | N_DOM | One-cycle sleep request per domain |
| wake_req | input | N_DOM | One-cycle wake request per domain |
| pwr_ack | input | N_DOM | Power-good acknowledge per domain |
| dom_din | input | N_DOM*DATA_W | Data leaving each domain |
| sw_en | output | N_DOM | Power switch enable |
| iso_en | output | N_DOM | Isolation clamp enable |
| save_pls | output | N_DOM | Retention save strobe |
| rest_pls | output | N_DOM | Retention restore strobe |
| clk_en | output | N_DOM | Domain clock enable |
| dom_status | output | 3*N_DOM | Status code per domain |
| fault | output | N_DOM | Sticky timeout fault |
| dom_dout | output | N_DOM*DATA_W | Isolated data toward powered logic |

## Verification
The properties assume the acknowledge of each domain stays stable between the switch edge and its arrival. They also assume it stays high while the domain is powered, so a restore only ever follows an acknowledge that is still present. The ack model in the bench follows each switch enable through a fixed per-domain delay, and one domain has an acknowledge stuck high, which exercises the power-off timeout. Requests are single-cycle pulses driven on the falling edge, and the timeout limit only changes while no wait is in progress.

// File: rtl/pgc_pkg.sv
// Package: shared sequencer states and status codes for the power-gating controller.
// Assumes: status encodings are fixed by the external interface.
package pgc_pkg;

    typedef enum logic [3:0] {
        ST_ON,      // powered, clocked, unclamped
        ST_CLKOFF,  // clock stopped
        ST_ISO,     // clamps applied
        ST_SAVE,    // shadow-register save strobe
        ST_SWOFF,   // switch opened, waiting for ack low
        ST_OFF,     // unpowered, retention only
        ST_SWON,    // switch closed, waiting for ack high
        ST_REST,    // restore strobe
        ST_CLKON,   // clock running, clamps still on
        ST_ERR      // acknowledge timeout, parked safe
    } pgc_state_e;

    localparam logic [2:0] STAT_ON       = 3'd0;
    localparam logic [2:0] STAT_GOING_OFF = 3'd1;
    localparam logic [2:0] STAT_OFF      = 3'd2;
    localparam logic [2:0] STAT_GOING_ON = 3'd3;
    localparam logic [2:0] STAT_ERROR    = 3'd4;

    // Map an internal state onto the reported status code.
    function automatic logic [2:0] status_of(pgc_state_e s);
        case (s)
            ST_ON:                               return STAT_ON;
            ST_CLKOFF, ST_ISO, ST_SAVE, ST_SWOFF: return STAT_GOING_OFF;
            ST_OFF:                              return STAT_OFF;
            ST_SWON, ST_REST, ST_CLKON:          return STAT_GOING_ON;
            default:                             return STAT_ERROR;
        endcase
    endfunction

endpackage

// File: rtl/pgc_ack_timer.sv
// Module: counts cycles spent waiting for a switch acknowledge.
// Assumes: 'run' is low for at least one cycle before each wait, so every
// wait starts from zero. A limit of 0 behaves as 2**TMO_W.
module pgc_ack_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;

    // Count while waiting, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    // Last permitted wait cycle reached.
    always_comb expired = run && (cnt_q == TMO_W'(limit - 1'b1));

endmodule

// File: rtl/pgc_dom_seq.sv
// Module: per-domain power sequencer. It orders clock stop, clamp, save and
// switch-off on the way down, and switch-on, restore, clock start and
// unclamp on the way up.
// Assumes: requests are single-cycle pulses; pwr_ack is synchronous to clk.
module pgc_dom_seq
    import pgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       pwr_ack,
    input  logic       tmo_expired,
    output logic       wait_ack,
    output logic       sw_en,
    output logic       iso_en,
    output logic       save_pls,
    output logic       rest_pls,
    output logic       clk_en,
    output logic [2:0] status,
    output logic       fault
);

    pgc_state_e state_q, state_n;
    logic       pend_q, pend_n;
    logic       fault_q;

    // Next-state selection; every sequence runs to completion.
    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_ON:     if (sleep_req) state_n = ST_CLKOFF;
            ST_CLKOFF: state_n = ST_ISO;
            ST_ISO:    state_n = ST_SAVE;
            ST_SAVE:   state_n = ST_SWOFF;
            ST_SWOFF:  if (!pwr_ack) state_n = ST_OFF;
                       else if (tmo_expired) state_n = ST_ERR;
            ST_OFF:    if (pend_q || wake_req) state_n = ST_SWON;
            ST_SWON:   if (pwr_ack) state_n = ST_REST;
                       else if (tmo_expired) state_n = ST_ERR;
            ST_REST:   state_n = ST_CLKON;
            ST_CLKON:  state_n = ST_ON;
            default:   state_n = ST_ERR;
        endcase
    end

    // Remember a wake seen during shutdown until OFF is reached.
    always_comb begin
        pend_n = 1'b0;
        if (state_q != ST_ON &&
            (state_n == ST_CLKOFF || state_n == ST_ISO || state_n == ST_SAVE ||
             state_n == ST_SWOFF  || state_n == ST_OFF))
            pend_n = pend_q || wake_req;
    end

    // State, pending-wake and sticky fault registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ON;
            pend_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
            if (state_n == ST_ERR) fault_q <= 1'b1;
        end
    end

    // Moore decode of the domain control outputs.
    always_comb begin
        sw_en    = !(state_q == ST_SWOFF || state_q == ST_OFF || state_q == ST_ERR);
        iso_en   = !(state_q == ST_ON || state_q == ST_CLKOFF);
        clk_en   = (state_q == ST_ON) || (state_q == ST_CLKON);
        save_pls = (state_q == ST_SAVE);
        rest_pls = (state_q == ST_REST);
        wait_ack = (state_q == ST_SWOFF) || (state_q == ST_SWON);
        status   = status_of(state_q);
        fault    = fault_q;
    end

endmodule

// File: rtl/pgc_iso_bank.sv
// Module: clamp cells for one domain's outward data bits.
// Assumes: clamp values are fixed at build time, one per bit.
module pgc_iso_bank #(
    parameter int                DATA_W = 4,
    parameter logic [DATA_W-1:0] CLAMP  = '0
) (
    input  logic              iso,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // One clamp per bit, forced to its own level while isolated.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign dout[b] = iso ? CLAMP[b] : din[b];
    end

endmodule

// File: rtl/pgc_ctrl.sv
// Module: top of the power-gating controller; one sequencer, one ack timer
// and one isolation bank for each domain.
// Assumes: all domains share clk and the timeout limit.
module pgc_ctrl
    import pgc_pkg::*;
#(
    parameter int                       N_DOM     = 4,
    parameter int                       DATA_W    = 4,
    parameter int                       TMO_W     = 8,
    parameter logic [N_DOM*DATA_W-1:0]  CLAMP_PAT = 16'h3C96
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TMO_W-1:0]          tmo_limit,
    input  logic [N_DOM-1:0]          sleep_req,
    input  logic [N_DOM-1:0]          wake_req,
    input  logic [N_DOM-1:0]          pwr_ack,
    input  logic [N_DOM*DATA_W-1:0]   dom_din,
    output logic [N_DOM-1:0]          sw_en,
    output logic [N_DOM-1:0]          iso_en,
    output logic [N_DOM-1:0]          save_pls,
    output logic [N_DOM-1:0]          rest_pls,
    output logic [N_DOM-1:0]          clk_en,
    output logic [3*N_DOM-1:0]        dom_status,
    output logic [N_DOM-1:0]          fault,
    output logic [N_DOM*DATA_W-1:0]   dom_dout
);

    logic [N_DOM-1:0] wait_ack;
    logic [N_DOM-1:0] tmo_hit;

    // Replicate the per-domain slice.
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        pgc_ack_timer #(.TMO_W(TMO_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (wait_ack[d]),
            .limit   (tmo_limit),
            .expired (tmo_hit[d])
        );

        pgc_dom_seq u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .sleep_req   (sleep_req[d]),
            .wake_req    (wake_req[d]),
            .pwr_ack     (pwr_ack[d]),
            .tmo_expired (tmo_hit[d]),
            .wait_ack    (wait_ack[d]),
            .sw_en       (sw_en[d]),
            .iso_en      (iso_en[d]),
            .save_pls    (save_pls[d]),
            .rest_pls    (rest_pls[d]),
            .clk_en      (clk_en[d]),
            .status      (dom_status[3*d +: 3]),
            .fault       (fault[d])
        );

        pgc_iso_bank #(
            .DATA_W (DATA_W),
            .CLAMP  (CLAMP_PAT[DATA_W*d +: DATA_W])
        ) u_iso (
            .iso  (iso_en[d]),
            .din  (dom_din[DATA_W*d +: DATA_W]),
            .dout (dom_dout[DATA_W*d +: DATA_W])
        );
    end

endmodule

// File: rtl/pgc_chk.sv
// Module: protocol checker for pgc_ctrl, attached with bind.
// Assumes: pwr_ack stays high while a powered domain runs.
module pgc_chk #(
    parameter int                      N_DOM     = 4,
    parameter int                      DATA_W    = 4,
    parameter logic [N_DOM*DATA_W-1:0] CLAMP_PAT = 16'h3C96
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_DOM-1:0]        pwr_ack,
    input logic [N_DOM*DATA_W-1:0] dom_din,
    input logic [N_DOM-1:0]        sw_en,
    input logic [N_DOM-1:0]        iso_en,
    input logic [N_DOM-1:0]        save_pls,
    input logic [N_DOM-1:0]        rest_pls,
    input logic [N_DOM-1:0]        clk_en,
    input logic [3*N_DOM-1:0]      dom_status,
    input logic [N_DOM-1:0]        fault,
    input logic [N_DOM*DATA_W-1:0] dom_dout
);

    for (genvar d = 0; d < N_DOM; d++) begin : g_chk
        // R10
        save_rest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(save_pls[d] && rest_pls[d]));
        // R10
        save_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            save_pls[d] |=> !save_pls[d]);
        // R2
        save_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
            save_pls[d] |-> (iso_en[d] && sw_en[d] && !clk_en[d]));
        // R2
        switch_off_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sw_en[d]) |-> (iso_en[d] && !clk_en[d]));
        // R4
        restore_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rest_pls[d] |-> ($past(pwr_ack[d]) && sw_en[d] && iso_en[d] && !clk_en[d]));
        // R4
        unclamp_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(iso_en[d]) |-> (clk_en[d] && $past(clk_en[d])));
        // R7
        fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault[d] |=> fault[d]);
        // R7
        fault_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault[d] |-> (iso_en[d] && !sw_en[d] && !clk_en[d]));
        // R3
        status_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dom_status[3*d +: 3] <= 3'd4);
        // R8
        clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dom_dout[DATA_W*d +: DATA_W] ==
            (iso_en[d] ? CLAMP_PAT[DATA_W*d +: DATA_W] : dom_din[DATA_W*d +: DATA_W]));
    end

endmodule

bind pgc_ctrl pgc_chk #(
    .N_DOM     (N_DOM),
    .DATA_W    (DATA_W),
    .CLAMP_PAT (CLAMP_PAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ack    (pwr_ack),
    .dom_din    (dom_din),
    .sw_en      (sw_en),
    .iso_en     (iso_en),
    .save_pls   (save_pls),
    .rest_pls   (rest_pls),
    .clk_en     (clk_en),
    .dom_status (dom_status),
    .fault      (fault),
    .dom_dout   (dom_dout)
);

// File: tb/sim_pgc_ctrl.sv
// Bench: scoreboard of status transitions plus cycle-exact sequencing checks.
module sim_pgc_ctrl;

    localparam int ND = 4;
    localparam int DW = 4;
    localparam int TW = 8;
    localparam logic [ND*DW-1:0] CLAMP = 16'h3C96;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TW-1:0]    tmo_limit = 8'd8;
    logic [ND-1:0]    sleep_req = '0;
    logic [ND-1:0]    wake_req = '0;
    logic [ND-1:0]    pwr_ack;
    logic [ND*DW-1:0] dom_din = 16'h5A1E;
    logic [ND-1:0]    sw_en, iso_en, save_pls, rest_pls, clk_en, fault;
    logic [3*ND-1:0]  dom_status;
    logic [ND*DW-1:0] dom_dout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pgc_ctrl #(.N_DOM(ND), .DATA_W(DW), .TMO_W(TW), .CLAMP_PAT(CLAMP)) u0 (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .sleep_req(sleep_req), .wake_req(wake_req), .pwr_ack(pwr_ack),
        .dom_din(dom_din), .sw_en(sw_en), .iso_en(iso_en),
        .save_pls(save_pls), .rest_pls(rest_pls), .clk_en(clk_en),
        .dom_status(dom_status), .fault(fault), .dom_dout(dom_dout)
    );

    // Switch network model: ack follows sw_en after a per-domain delay; domain 2 is stuck high.
    logic [7:0] ack_pipe [ND];
    always @(posedge clk) begin
        for (int d = 0; d < ND; d++)
            if (!rst_n) ack_pipe[d] <= '1;
            else        ack_pipe[d] <= {ack_pipe[d][6:0], sw_en[d]};
    end
    assign pwr_ack[0] = ack_pipe[0][0];
    assign pwr_ack[1] = ack_pipe[1][3];
    assign pwr_ack[2] = 1'b1;
    assign pwr_ack[3] = ack_pipe[3][1];

    function automatic logic [2:0] st(int d);
        return dom_status[3*d +: 3];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Scoreboard: expected status transitions per domain.
    logic [2:0] expq [ND][$];
    logic [2:0] prev [ND];

    task automatic expect_seq(input int d, input logic [2:0] s);
        expq[d].push_back(s);
    endtask

    // Monitor: compare every observed status change against the expected queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int d = 0; d < ND; d++) begin
                if (st(d) != prev[d]) begin
                    if (expq[d].size() == 0)
                        check(1'b0, "R3 unexpected transition", int'(st(d)), 7);
                    else
                        check(st(d) == expq[d].pop_front(), "R3 transition order", int'(st(d)), -1);
                    prev[d] = st(d);
                end
            end
        end
    end

    task automatic wait_stat(input int d, input logic [2:0] s, input string req);
        int n = 0;
        while (st(d) != s && n < 60) begin tick(); n++; end
        check(st(d) == s, req, int'(st(d)), int'(s));
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        for (int d = 0; d < ND; d++) prev[d] = 3'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(dom_status == '0, "R1 status", int'(dom_status), 0);
        check(clk_en == '1 && sw_en == '1, "R1 clk/sw", int'({clk_en, sw_en}), 8'hFF);
        check(iso_en == '0 && fault == '0, "R1 iso/fault", int'({iso_en, fault}), 0);
        check(save_pls == '0 && rest_pls == '0, "R1 strobes", int'({save_pls, rest_pls}), 0);
        // R8 pass-through while unclamped
        check(dom_dout == dom_din, "R8 passthrough", int'(dom_dout), int'(dom_din));

        // R2 shutdown order on domain 0
        expect_seq(0, 3'd1); expect_seq(0, 3'd2);
        sleep_req[0] = 1'b1; tick(); sleep_req[0] = 1'b0;
        check(!clk_en[0] && !iso_en[0] && sw_en[0], "R2 clock stop first", int'({clk_en[0], iso_en[0], sw_en[0]}), 1);
        tick();
        check(iso_en[0] && !save_pls[0], "R2 clamp second", int'({iso_en[0], save_pls[0]}), 2);
        tick();
        check(save_pls[0] && sw_en[0], "R2 save pulse", int'({save_pls[0], sw_en[0]}), 3);
        tick();
        check(!save_pls[0] && !sw_en[0] && iso_en[0], "R2 switch open", int'({save_pls[0], sw_en[0], iso_en[0]}), 1);
        wait_stat(0, 3'd2, "R3 reach OFF");
        check(pwr_ack[0] == 1'b0, "R3 ack low at OFF", int'(pwr_ack[0]), 0);
        check(dom_dout[3:0] == 4'h6, "R8 clamp dom0", int'(dom_dout[3:0]), 6);
        check(st(1) == 3'd0 && clk_en[1], "R9 neighbour untouched", int'(st(1)), 0);

        // R6 sleep while OFF is ignored
        begin
            bit saw_save = 1'b0;
            sleep_req[0] = 1'b1; tick(); sleep_req[0] = 1'b0;
            repeat (4) begin saw_save |= save_pls[0]; tick(); end
            check(st(0) == 3'd2 && !sw_en[0] && !saw_save, "R6 sleep ignored in OFF", int'(st(0)), 2);
        end

        // R4 wake-up order on domain 0
        expect_seq(0, 3'd3); expect_seq(0, 3'd0);
        wake_req[0] = 1'b1; tick(); wake_req[0] = 1'b0;
        check(sw_en[0] && iso_en[0] && !clk_en[0], "R4 switch closed first", int'({sw_en[0], iso_en[0], clk_en[0]}), 6);
        begin
            int n = 0;
            while (!rest_pls[0] && n < 20) begin tick(); n++; end
        end
        check(rest_pls[0] && pwr_ack[0] && !clk_en[0] && iso_en[0], "R4 restore after ack",
              int'({rest_pls[0], pwr_ack[0], clk_en[0], iso_en[0]}), 4'b1101);
        tick();
        check(!rest_pls[0] && clk_en[0] && iso_en[0], "R4 clock then", int'({rest_pls[0], clk_en[0], iso_en[0]}), 3);
        tick();
        check(!iso_en[0] && st(0) == 3'd0, "R4 unclamp last", int'({iso_en[0], st(0)}), 0);
        check(dom_dout[3:0] == dom_din[3:0], "R8 released dom0", int'(dom_dout[3:0]), int'(dom_din[3:0]));

        // R6 wake while ON is ignored
        wake_req[3] = 1'b1; tick(); wake_req[3] = 1'b0;
        repeat (4) tick();
        check(st(3) == 3'd0 && sw_en[3] && clk_en[3] && !iso_en[3], "R6 wake ignored in ON", int'(st(3)), 0);

        // R5 wake held during shutdown on domain 1
        expect_seq(1, 3'd1); expect_seq(1, 3'd2); expect_seq(1, 3'd3); expect_seq(1, 3'd0);
        begin
            bit went_off = 1'b0;
            int n = 0;
            sleep_req[1] = 1'b1; tick(); sleep_req[1] = 1'b0;
            wake_req[1] = 1'b1;  tick(); wake_req[1] = 1'b0;
            while (!(st(1) == 3'd0 && !iso_en[1]) && n < 60) begin
                went_off |= (st(1) == 3'd2 && !sw_en[1]);
                tick(); n++;
            end
            check(went_off, "R5 full shutdown before wake", int'(went_off), 1);
            check(st(1) == 3'd0 && !iso_en[1], "R5 pending wake served", int'(st(1)), 0);
        end

        // R9 two domains shut down together, others stay on
        expect_seq(0, 3'd1); expect_seq(0, 3'd2);
        expect_seq(3, 3'd1); expect_seq(3, 3'd2);
        sleep_req[0] = 1'b1; sleep_req[3] = 1'b1; tick(); sleep_req = '0;
        wait_stat(0, 3'd2, "R9 dom0 off");
        wait_stat(3, 3'd2, "R9 dom3 off");
        check(st(1) == 3'd0 && st(2) == 3'd0 && clk_en[1] && clk_en[2], "R9 others on", int'({st(2), st(1)}), 0);
        check(dom_dout[15:12] == 4'h3, "R8 clamp dom3", int'(dom_dout[15:12]), 3);

        // R7 power-off timeout on domain 2 (ack stuck high), limit 6
        tmo_limit = 8'd6;
        expect_seq(2, 3'd1); expect_seq(2, 3'd4);
        sleep_req[2] = 1'b1; tick(); sleep_req[2] = 1'b0;
        repeat (8) tick();
        check(st(2) == 3'd1 && !fault[2], "R7 still waiting at limit-1", int'(st(2)), 1);
        tick();
        check(st(2) == 3'd4 && fault[2], "R7 error at limit", int'(st(2)), 4);
        check(iso_en[2] && !sw_en[2] && !clk_en[2], "R7 safe outputs", int'({iso_en[2], sw_en[2], clk_en[2]}), 4);
        check(dom_dout[11:8] == 4'hC, "R8 clamp dom2", int'(dom_dout[11:8]), 12);
        wake_req[2] = 1'b1; tick(); wake_req[2] = 1'b0;
        sleep_req[2] = 1'b1; tick(); sleep_req[2] = 1'b0;
        repeat (3) tick();
        check(st(2) == 3'd4 && fault[2] && !rest_pls[2], "R7 sticky, requests ignored", int'(st(2)), 4);
        check(st(1) == 3'd0, "R9 dom1 unaffected by error", int'(st(1)), 0);

        // R3 every expected transition consumed
        for (int d = 0; d < ND; d++)
            check(expq[d].size() == 0, "R3 scoreboard drained", expq[d].size(), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule